// File: doc/BRIEF.md
# Per-Core Sticky Pin Event Capture

Each processor core holds one copy of this block. It watches 64 pin input lines and keeps one sticky bit per pin that records whether that pin has reported an event since software last cleared it. An event source reports an event with a single-cycle pulse rather than a level held until acknowledged. For pins in plain input mode, a one-cycle delayed copy of the level turns each rising edge into one set pulse, so a level held high is counted once. An inverted input upstream therefore makes the bit record falling edges.

The core reads a 64-bit value in which each pin shows either its raw level or its event view, chosen per pin. The event view is the latched bit OR'd with a pulse arriving in the same cycle, so a read never misses a pulse that is arriving as it happens. An acknowledge carries a 64-bit mask and re-samples the masked bits in one cycle. A masked bit whose pin pulses in that same cycle stays set; any other masked bit is cleared. A per-pin overrun flag records a pulse that arrived while the bit was already set. A wake output goes high in the cycle of any set pulse, so wait-for-event logic is released without an acknowledge. Because each core has its own instance, an acknowledge in one core never changes what another core sees.

Top module: `pin_event_capture`

## Requirements
- R1: After reset all event and overrun bits are 0. With no pin activity, every pin read in event view returns 0 and `ovr_flags` is 0.
- R2: In pulse mode (`edge_mode` bit = 0), a pin that is high in a cycle sets its event bit at the next clock edge. The bit stays 1 after the pin returns low, until it is acknowledged.
- R3: In event view (`read_sel` bit = 1), `read_val` for a pin is 1 in the same cycle as a set pulse on that pin, even before the bit is latched.
- R4: In raw view (`read_sel` bit = 0), `read_val` for a pin equals the current `pin_in` level for that pin, whatever the state of its event bit.
- R5: When `ack_valid` is 1, every event bit set in `ack_mask` is cleared at the next edge unless its pin has a set pulse in that cycle. Bits outside the mask are unchanged.
- R6: A set pulse in the same cycle as an acknowledge that covers the same pin wins: the event bit is 1 after the edge.
- R7: In edge mode (`edge_mode` bit = 1), the set pulse is `pin_in` high while the previous cycle's level was low. A level held high sets the bit only once and does not set it again after an acknowledge. The stored previous level is 0 after reset.
- R8: An overrun bit becomes 1 when a set pulse arrives on a pin whose event bit is already 1 and which is not being acknowledged in that cycle. An acknowledge covering the pin clears the overrun bit at the same edge as the event bit.
- R9: `wake` is 1 in exactly the cycles in which at least one pin has a set pulse, in either mode, with no acknowledge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 64 | Pin input lines, one bit per pin |
| edge_mode | input | 64 | Per pin: 1 = plain input, set on rising edge; 0 = pulse from peripheral |
| read_sel | input | 64 | Per pin: 1 = event view, 0 = raw pin level |
| ack_valid | input | 1 | Acknowledge strobe for this core |
| ack_mask | input | 64 | Bits to re-sample on acknowledge |
| read_val | output | 64 | Value returned to the core |
| ovr_flags | output | 64 | Per-pin overrun flags |
| wake | output | 1 | High in any cycle with a set pulse |

## Verification
A wrong event bit does not show up directly. It appears in `read_val` for pins in event view one cycle after the pulse or acknowledge that corrupted it, and it stays visible there until the next acknowledge. A wrong overrun bit shows on `ovr_flags` at the edge after the offending pulse. A wrong stored previous level in edge mode shows only when the next rising or held level on that pin fails to set the bit, or sets it twice. Acknowledge-versus-pulse collisions and held levels across an acknowledge are therefore exercised deliberately and then read back in the following cycle.

// File: rtl/pin_event_capture.sv
module pin_event_capture #(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] edge_mode,
  input  logic [NPINS-1:0] read_sel,
  input  logic             ack_valid,
  input  logic [NPINS-1:0] ack_mask,
  output logic [NPINS-1:0] read_val,
  output logic [NPINS-1:0] ovr_flags,
  output logic             wake
);

  logic [NPINS-1:0] evt_q, ovr_q, prev_q;
  logic [NPINS-1:0] set_pulse, clr;

  assign set_pulse = pin_in & ~(edge_mode & prev_q);
  assign clr       = ack_valid ? ack_mask : '0;
  assign read_val  = (read_sel & (evt_q | set_pulse)) | (~read_sel & pin_in);
  assign ovr_flags = ovr_q;
  assign wake      = |set_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      ovr_q  <= '0;
      prev_q <= '0;
    end else begin
      evt_q  <= (evt_q & ~clr) | set_pulse;
      ovr_q  <= (ovr_q | (set_pulse & evt_q)) & ~clr;
      prev_q <= pin_in;
    end
  end

  // R2
  set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((evt_q & $past(set_pulse)) == $past(set_pulse)));

  // R5
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((evt_q & $past(evt_q & ~clr)) == $past(evt_q & ~clr)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ((evt_q & $past(ack_mask & ~set_pulse)) == '0));

  // R8
  ovr_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_q & ~evt_q) == '0));

  // R9
  wake_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (|evt_q));

endmodule

// File: tb/pin_event_capture_tb_top.sv
module pin_event_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_in = '0, edge_mode = '0, read_sel = '0, ack_mask = '0;
  logic ack_valid = 0;
  logic [N-1:0] read_val, ovr_flags;
  logic wake;

  int checks = 0, errors = 0;
  logic [N-1:0] m_evt = '0, m_ovr = '0, m_prev = '0;

  logic [N-1:0] q_rd[$];
  logic [N-1:0] q_ov[$];
  logic         q_wk[$];
  string        q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_capture #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_mode(edge_mode),
    .read_sel(read_sel), .ack_valid(ack_valid), .ack_mask(ack_mask),
    .read_val(read_val), .ovr_flags(ovr_flags), .wake(wake));

  task automatic drive(input logic [N-1:0] pins, input logic [N-1:0] mode,
                       input logic [N-1:0] sel, input logic ack,
                       input logic [N-1:0] mask, input string tag);
    logic [N-1:0] sp, clr;
    @(negedge clk); #1;
    pin_in = pins; edge_mode = mode; read_sel = sel; ack_valid = ack; ack_mask = mask;
    sp = pins & ~(mode & m_prev);
    clr = ack ? mask : '0;
    q_rd.push_back((sel & (m_evt | sp)) | (~sel & pins));
    q_ov.push_back(m_ovr);
    q_wk.push_back(|sp);
    q_tag.push_back(tag);
    m_ovr  = (m_ovr | (sp & m_evt)) & ~clr;
    m_evt  = (m_evt & ~clr) | sp;
    m_prev = pins;
  endtask

  initial begin
    forever begin
      @(negedge clk); #3;
      if (q_rd.size() > 0) begin
        logic [N-1:0] erd, eov;
        logic ewk;
        string t;
        erd = q_rd.pop_front(); eov = q_ov.pop_front();
        ewk = q_wk.pop_front(); t = q_tag.pop_front();
        checks += 3;
        if (read_val !== erd) begin
          errors++; $display("FAIL %s read_val actual=%h expected=%h", t, read_val, erd);
        end
        if (ovr_flags !== eov) begin
          errors++; $display("FAIL %s ovr_flags actual=%h expected=%h", t, ovr_flags, eov);
        end
        if (wake !== ewk) begin
          errors++; $display("FAIL %s wake actual=%b expected=%b", t, wake, ewk);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [N-1:0] ALL = '1;
  localparam logic [N-1:0] B0  = 64'h1;
  localparam logic [N-1:0] B3  = 64'h8;
  localparam logic [N-1:0] B10 = 64'h400;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state in event view
    drive('0, '0, ALL, 0, '0, "R1 reset");
    drive('0, '0, ALL, 0, '0, "R1 idle");
    // R3 same-cycle passthrough, R9 wake
    drive(B3, '0, ALL, 0, '0, "R3 R9 pulse passthrough");
    // R2 latched after pin low
    drive('0, '0, ALL, 0, '0, "R2 latched");
    drive('0, '0, ALL, 0, '0, "R2 still latched");
    // R4 raw view
    drive(64'hA5, '0, '0, 0, '0, "R4 raw view");
    drive('0, '0, '0, 0, '0, "R4 raw low with events set");
    // R8 overrun on already-set pin
    drive(B3, '0, ALL, 0, '0, "R8 pulse on set bit");
    drive('0, '0, ALL, 0, '0, "R8 overrun visible");
    // R5 ack clears masked only
    drive('0, '0, ALL, 1, B3, "R5 ack bit3");
    drive('0, '0, ALL, 0, '0, "R5 R8 after ack");
    // R6 pulse wins over ack
    drive(B0, '0, ALL, 1, B0, "R6 ack with pulse");
    drive('0, '0, ALL, 0, '0, "R6 bit stays");
    drive('0, '0, ALL, 1, ALL, "R5 ack all");
    drive('0, '0, ALL, 0, '0, "R5 all clear");
    // R7 edge mode, level held across ack
    drive(B10, ALL, ALL, 0, '0, "R7 rising edge");
    drive(B10, ALL, ALL, 1, B10, "R7 held high with ack");
    drive(B10, ALL, ALL, 0, '0, "R7 held no reset");
    drive(B10, ALL, ALL, 0, '0, "R7 held still clear");
    drive('0, ALL, ALL, 0, '0, "R7 falling no set");
    drive(B10, ALL, ALL, 0, '0, "R7 new rising edge");
    drive('0, ALL, ALL, 0, '0, "R7 latched");
    drive(B10, ALL, ALL, 0, '0, "R8 edge overrun");
    drive('0, ALL, ALL, 1, ALL, "R5 clear all");
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] p, m, s, k;
      p = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      m = {$urandom, $urandom};
      s = {$urandom, $urandom};
      k = {$urandom, $urandom};
      drive(p, m, s, ($urandom % 3) == 0, k, "R2 R5 R6 R7 R8 mixed");
    end
    drive('0, '0, ALL, 0, '0, "R2 final");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule